// File: doc/BRIEF.md
# Indirect Wide-Address Bus Extender

This block joins a host bus that carries N data bits to a secondary bus that carries N data bits and 2N address bits. It takes up only three host I/O locations. Software sends the wide target address through the host data bus in two pieces: first the lower half, then the upper half, each to its own location. It then writes the payload to the third location. That final write places the assembled address and the payload on the secondary bus for one clock cycle.

The host side is a 16-bit address, a data word and a write strobe. A decoder compares the address against three parameterised locations and accepts only writes. Two half-address registers keep whatever software last stored in them. A two-state sequencer, with states IDLE and DRIVE, controls the secondary-bus enables.

The sequencer has these transitions:
- IDLE to DRIVE (GO) on a data write.
- DRIVE to DRIVE (CHAIN) when another data write follows at once.
- DRIVE to IDLE (DONE) in any other case.
- Any state to IDLE (CLEAR) on reset.

The secondary address and data lines are each a value paired with an enable, so a pad ring can tri-state them. While the enable is low, the value is held at zero.

Top module: `wab_bridge`

## Requirements
- R1: A synchronous active-high reset clears both stored address halves to zero and forces `nb_addr_oe`, `nb_data_oe` and `nb_wr` low. A data write as the first access after reset therefore drives address zero.
- R2: A location is selected only when `host_wr` is 1 and `host_addr` exactly equals that location. Reads, idle cycles and writes to other addresses change neither the stored halves nor the secondary-bus outputs.
- R3: A write to `LOC_LO` stores `host_wdata` as bits [N-1:0] of the secondary address.
- R4: A write to `LOC_HI` stores `host_wdata` as bits [2N-1:N] of the secondary address.
- R5: A write to `LOC_DAT` in cycle k makes cycle k+1 carry `nb_addr` = {high half, low half} and `nb_data` equal to the host data word of cycle k.
- R6: `nb_addr_oe`, `nb_data_oe` and `nb_wr` are high in cycle k+1 exactly when cycle k held a data write. Back-to-back data writes give consecutive drive cycles.
- R7: Whenever the enables are low, `nb_addr` and `nb_data` are zero. This holds during half-address writes.
- R8: The stored halves survive a data write. A repeated data write alone reuses the last address, and writing one half leaves the other half unchanged.
- R9: A half-address write made in the cycle the bus is being driven does not alter the address currently on the bus. It takes effect from the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | HADDR_W (16) | Host I/O address |
| host_wdata | input | DATA_W | Host write data |
| host_wr | input | 1 | Host write strobe, active high |
| nb_addr | output | 2*DATA_W | Secondary-bus address value |
| nb_addr_oe | output | 1 | Secondary-bus address enable |
| nb_data | output | DATA_W | Secondary-bus data value |
| nb_data_oe | output | 1 | Secondary-bus data enable |
| nb_wr | output | 1 | Secondary-bus one-cycle write strobe |

## Verification
Two functions can fall in the same cycle: driving a finished transfer onto the secondary bus, and capturing a new address half for the next transfer. The bench provokes this by issuing a low-half or high-half write in the cycle right after a data write, and also by chaining data writes back to back. A cycle-accurate behavioural model judges each case. It expects the bus to show the old address during the overlapped cycle and the new half only on the following transfer. A long pseudo-random stretch mixes all host operations, including near-miss addresses and reads.

// File: rtl/wab_pkg.sv
package wab_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DRIVE = 1'b1
    } wab_state_e;

    localparam int NUM_LOCS = 3;
    localparam int SEL_LO   = 0;
    localparam int SEL_HI   = 1;
    localparam int SEL_DAT  = 2;

endpackage

// File: rtl/wab_decoder.sv
module wab_decoder #(
    parameter int             HADDR_W = 16,
    parameter logic [15:0]    LOC_LO  = 16'h0300,
    parameter logic [15:0]    LOC_HI  = 16'h0301,
    parameter logic [15:0]    LOC_DAT = 16'h0302
) (
    input  logic [HADDR_W-1:0]          host_addr,
    input  logic                        host_wr,
    output logic [wab_pkg::NUM_LOCS-1:0] sel
);
    localparam logic [wab_pkg::NUM_LOCS-1:0][HADDR_W-1:0] LOCS =
        {HADDR_W'(LOC_DAT), HADDR_W'(LOC_HI), HADDR_W'(LOC_LO)};

    for (genvar i = 0; i < wab_pkg::NUM_LOCS; i++) begin : g_cmp
        assign sel[i] = host_wr && (host_addr == LOCS[i]);
    end

endmodule

// File: rtl/wab_addr_store.sv
module wab_addr_store #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          half_we,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] wide_addr
);
    logic [1:0][DATA_W-1:0] half_q;

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                half_q[h] <= '0;
            end else if (half_we[h]) begin
                half_q[h] <= wdata;
            end
        end
    end

    assign wide_addr = {half_q[1], half_q[0]};

endmodule

// File: rtl/wab_ctrl.sv
module wab_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dat_sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [2*DATA_W-1:0] wide_addr,
    output logic [2*DATA_W-1:0] nb_addr,
    output logic                nb_addr_oe,
    output logic [DATA_W-1:0]   nb_data,
    output logic                nb_data_oe,
    output logic                nb_wr
);
    import wab_pkg::*;

    wab_state_e           state_q, state_d;
    logic [2*DATA_W-1:0]  addr_q;
    logic [DATA_W-1:0]    data_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = dat_sel ? ST_DRIVE : ST_IDLE;   // GO
            ST_DRIVE: state_d = dat_sel ? ST_DRIVE : ST_IDLE;   // CHAIN / DONE
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register plus the snapshot of the transfer being launched
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (dat_sel) begin
                addr_q <= wide_addr;
                data_q <= wdata;
            end
        end
    end

    // Output decode
    always_comb begin
        nb_addr    = '0;
        nb_data    = '0;
        nb_addr_oe = 1'b0;
        nb_data_oe = 1'b0;
        nb_wr      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRIVE: begin
                nb_addr    = addr_q;
                nb_data    = data_q;
                nb_addr_oe = 1'b1;
                nb_data_oe = 1'b1;
                nb_wr      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wab_bridge.sv
module wab_bridge #(
    parameter int          DATA_W  = 8,
    parameter int          HADDR_W = 16,
    parameter logic [15:0] LOC_LO  = 16'h0300,
    parameter logic [15:0] LOC_HI  = 16'h0301,
    parameter logic [15:0] LOC_DAT = 16'h0302
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [HADDR_W-1:0]  host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic                host_wr,
    output logic [2*DATA_W-1:0] nb_addr,
    output logic                nb_addr_oe,
    output logic [DATA_W-1:0]   nb_data,
    output logic                nb_data_oe,
    output logic                nb_wr
);
    import wab_pkg::*;

    localparam int NB_AW = 2 * DATA_W;

    logic [NUM_LOCS-1:0] sel;
    logic [NB_AW-1:0]    wide_addr;

    wab_decoder #(
        .HADDR_W (HADDR_W),
        .LOC_LO  (LOC_LO),
        .LOC_HI  (LOC_HI),
        .LOC_DAT (LOC_DAT)
    ) u_dec (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .sel       (sel)
    );

    wab_addr_store #(
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .half_we   ({sel[SEL_HI], sel[SEL_LO]}),
        .wdata     (host_wdata),
        .wide_addr (wide_addr)
    );

    wab_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dat_sel    (sel[SEL_DAT]),
        .wdata      (host_wdata),
        .wide_addr  (wide_addr),
        .nb_addr    (nb_addr),
        .nb_addr_oe (nb_addr_oe),
        .nb_data    (nb_data),
        .nb_data_oe (nb_data_oe),
        .nb_wr      (nb_wr)
    );

endmodule

// File: rtl/wab_bridge_chk.sv
module wab_bridge_chk #(
    parameter int          DATA_W  = 8,
    parameter int          HADDR_W = 16,
    parameter logic [15:0] LOC_LO  = 16'h0300,
    parameter logic [15:0] LOC_HI  = 16'h0301,
    parameter logic [15:0] LOC_DAT = 16'h0302
) (
    input logic                clk,
    input logic                rst,
    input logic [HADDR_W-1:0]  host_addr,
    input logic [DATA_W-1:0]   host_wdata,
    input logic                host_wr,
    input logic [2*DATA_W-1:0] nb_addr,
    input logic                nb_addr_oe,
    input logic [DATA_W-1:0]   nb_data,
    input logic                nb_data_oe,
    input logic                nb_wr
);
    logic dat_wr, half_wr;
    assign dat_wr  = host_wr && (host_addr == HADDR_W'(LOC_DAT));
    assign half_wr = host_wr && ((host_addr == HADDR_W'(LOC_LO)) ||
                                 (host_addr == HADDR_W'(LOC_HI)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!nb_addr_oe && !nb_data_oe && !nb_wr));

    // R6
    drive_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(dat_wr) && !$past(rst)) |-> (nb_wr && nb_addr_oe && nb_data_oe));

    // R6
    no_spurious_drive_chk: assert property (@(posedge clk) disable iff (rst)
        nb_wr |-> $past(dat_wr));

    // R5
    data_word_chk: assert property (@(posedge clk) disable iff (rst)
        nb_data_oe |-> (nb_data == $past(host_wdata)));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !nb_addr_oe |-> (nb_addr == '0 && nb_data == '0));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nb_addr_oe && $past(nb_addr_oe) && !$past(half_wr, 2)) |-> $stable(nb_addr));

endmodule

bind wab_bridge wab_bridge_chk #(
    .DATA_W  (DATA_W),
    .HADDR_W (HADDR_W),
    .LOC_LO  (LOC_LO),
    .LOC_HI  (LOC_HI),
    .LOC_DAT (LOC_DAT)
) u_chk (.*);

// File: tb/sim_wab_bridge.sv
`timescale 1ns/1ps
module sim_wab_bridge;
    localparam int          DW   = 8;
    localparam logic [15:0] A_LO = 16'h0300;
    localparam logic [15:0] A_HI = 16'h0301;
    localparam logic [15:0] A_DT = 16'h0302;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_wr = 1'b0;
    logic [2*DW-1:0] nb_addr;
    logic          nb_addr_oe, nb_data_oe, nb_wr;
    logic [DW-1:0] nb_data;

    always #2 clk = ~clk;

    wab_bridge #(.DATA_W(DW), .HADDR_W(16), .LOC_LO(A_LO), .LOC_HI(A_HI), .LOC_DAT(A_DT)) u0 (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
        .nb_addr(nb_addr), .nb_addr_oe(nb_addr_oe), .nb_data(nb_data),
        .nb_data_oe(nb_data_oe), .nb_wr(nb_wr));

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // behavioural model state
    int m_lo = 0, m_hi = 0;
    int e_oe = 0, e_addr = 0, e_data = 0;

    task automatic step(input logic [15:0] a, input logic [DW-1:0] d, input bit w,
                        input bit r, input string tag);
        host_addr = a; host_wdata = d; host_wr = w; rst = r;
        @(posedge clk);
        if (r) begin
            m_lo = 0; m_hi = 0; e_oe = 0; e_addr = 0; e_data = 0;
        end else begin
            e_oe   = (w && a == A_DT) ? 1 : 0;
            e_addr = e_oe ? ((m_hi << DW) | m_lo) : 0;
            e_data = e_oe ? int'(d) : 0;
            if (w && a == A_LO) m_lo = int'(d);
            if (w && a == A_HI) m_hi = int'(d);
        end
        @(negedge clk);
        vectors++;
        if (nb_addr_oe !== e_oe[0] || nb_data_oe !== e_oe[0] || nb_wr !== e_oe[0] ||
            nb_addr !== e_addr[2*DW-1:0] || nb_data !== e_data[DW-1:0]) begin
            fails++;
            $display("FAIL %s: got oe=%0b/%0b wr=%0b addr=%h data=%h, expected oe=%0d wr=%0d addr=%h data=%h",
                     tag, nb_addr_oe, nb_data_oe, nb_wr, nb_addr, nb_data,
                     e_oe, e_oe, e_addr[2*DW-1:0], e_data[DW-1:0]);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        // R1 reset state
        step(A_DT, 8'h55, 1'b1, 1'b1, "R1 reset");
        step(A_LO, 8'h11, 1'b1, 1'b1, "R1 reset hold");
        // R1 data write straight after reset uses address zero
        step(A_DT, 8'hA5, 1'b1, 1'b0, "R1 cleared halves");
        step(16'h0000, 8'h00, 1'b0, 1'b0, "R6 single pulse");
        // R3 R4 R5 full sequence
        step(A_LO, 8'h34, 1'b1, 1'b0, "R7 quiet during low write");
        step(A_HI, 8'h12, 1'b1, 1'b0, "R7 quiet during high write");
        step(A_DT, 8'hC3, 1'b1, 1'b0, "R5 transfer");
        step(16'h0000, 8'h00, 1'b0, 1'b0, "R3 R4 idle after");
        // R2 reads and near-miss addresses are ignored
        step(A_LO, 8'hEE, 1'b0, 1'b0, "R2 read low");
        step(A_HI, 8'hDD, 1'b0, 1'b0, "R2 read high");
        step(A_DT, 8'hCC, 1'b0, 1'b0, "R2 read data");
        step(16'h0303, 8'h99, 1'b1, 1'b0, "R2 near miss");
        step(16'h1300, 8'h98, 1'b1, 1'b0, "R2 far miss");
        step(A_DT, 8'h01, 1'b1, 1'b0, "R2 halves unchanged");
        // R8 repeat data write reuses address, back-to-back chain (R6)
        step(A_DT, 8'h02, 1'b1, 1'b0, "R8 reuse");
        step(A_DT, 8'h03, 1'b1, 1'b0, "R6 chain");
        // R8 change only low half
        step(A_LO, 8'h78, 1'b1, 1'b0, "R8 low only");
        step(A_DT, 8'h04, 1'b1, 1'b0, "R8 high kept");
        // R9 half write during drive cycle
        step(A_HI, 8'h9A, 1'b1, 1'b0, "R9 overlap high");
        step(A_DT, 8'h05, 1'b1, 1'b0, "R9 new high next");
        step(A_LO, 8'hBC, 1'b1, 1'b0, "R9 overlap low");
        step(A_DT, 8'h06, 1'b1, 1'b0, "R9 new low next");
        step(16'h0000, 8'h00, 1'b0, 1'b0, "R6 end of chain");
        // mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            unique case (lfsr[2:0])
                3'd0, 3'd1: a = A_LO;
                3'd2, 3'd3: a = A_HI;
                3'd4, 3'd5: a = A_DT;
                3'd6:       a = 16'h0303;
                default:    a = 16'h02FF;
            endcase
            step(a, lfsr[15:8], lfsr[3] | lfsr[4], 1'b0, "R2 R5 R9 mixed");
        end
        // R1 reset in mid-run clears halves
        step(A_LO, 8'h44, 1'b1, 1'b1, "R1 mid reset");
        step(A_DT, 8'h07, 1'b1, 1'b0, "R1 cleared again");
        step(16'h0000, 8'h00, 1'b0, 1'b0, "R7 idle zero");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule